// File: doc/BRIEF.md
# External Interrupt and Key-Wakeup Front End

This block is the pin-facing half of the interrupt logic in a small 8-bit controller. Two external request pins and a bank of key-wakeup pins are each passed through a two-flop synchroniser. The block then detects the events on them and keeps them as sticky flags, which software clears by writing ones to the status register.

Each external request pin can react to a falling edge only, or to a falling edge and also a held low level. Both pins feed one shared request line toward the CPU's external-interrupt vector. A flag on these pins latches even while the pin is disabled. Software can therefore clear a stale flag before it sets the enable bit, or it can set the enable bit and take the pending request.

Every key pin has its own falling-edge latch. A set latch on a key selected by the key mask raises one common key flag. Clearing that flag empties all latches at once. The key request is the common flag gated by one global key enable.

Top module: `xirq_wake_ctrl`

## Requirements
- R1: After reset, all four registers read 0, and `xirq_req` and `key_req` are low. Register addresses: 0 = control, 1 = status, 2 = key mask, 3 = key latches (read-only).
- R2: A falling edge on `xirq_pin[i]` sets status bit i on the third rising clock edge after the pin changes, and not before. A rising edge sets nothing.
- R3: In edge mode (control bit 2+i = 0), a pin held low does not set flag i again after software clears it.
- R4: In level mode (control bit 2+i = 1), flag i stays set while the synchronised pin is low, even when a clear is written.
- R5: Flag i sets while enable bit i (control bit i) is 0. Setting the enable later raises `xirq_req`. Clearing the flag first keeps `xirq_req` low when enabling.
- R6: `xirq_req` is high exactly when (status bit 0 and control bit 0) or (status bit 1 and control bit 1) is true, so either pin alone drives the shared request.
- R7: A status write clears each flag whose data bit is 1 and leaves flags at 0-bits untouched. A new event in the same cycle as its clear leaves the flag set.
- R8: A falling edge on `key_pin[k]` sets key latch k (readable at address 3, bit k) whether or not the key is masked. A rising edge leaves the latches unchanged.
- R9: Status bit 4 (key flag) sets when a latch is set on a key whose mask bit (address 2, bit k) is 1. A latch on a key with mask bit 0 does not set it.
- R10: `key_req` is high exactly when status bit 4 and control bit 4 (global key enable) are both 1.
- R11: Writing 1 to status bit 4 clears the key flag and all key latches in the same cycle. A key edge that arrives in that cycle survives the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xirq_pin | input | 2 | Asynchronous external request pins, active low |
| key_pin | input | NUM_KEYS | Asynchronous key-wakeup pins, active on falling edge |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` (combinational) |
| xirq_req | output | 1 | Shared external interrupt request |
| key_req | output | 1 | Key-wakeup interrupt request |

## Verification
The external pins are driven with single falling edges, with rising edges, with lows held across a clear, and with a fall placed so that its detection lands in the same cycle as a clear. Together these separate edge sensing from level sensing and show which way a clear/set collision resolves. The pins are also exercised with the enable clear, set, and set only after a clear, which shows that a flag latches independently of its enable. The keys get edges on masked and unmasked inputs, rising edges, and a clear that meets a new edge. These show that the latch, the mask gate and the shared clear are separate stages.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int NUM_XIRQ = 2;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;

    // Register addresses
    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 2'd0,
        RA_STAT   = 2'd1,
        RA_KMASK  = 2'd2,
        RA_KLATCH = 2'd3
    } reg_addr_e;

    // Bit positions shared by control and status
    localparam int EN_LSB   = 0;
    localparam int LVL_LSB  = 2;
    localparam int KEY_BIT  = 4;

    typedef struct packed {
        logic                key_en;
        logic [NUM_XIRQ-1:0] lvl;
        logic [NUM_XIRQ-1:0] en;
    } ctrl_t;

    typedef struct packed {
        logic                key_flag;
        logic [NUM_XIRQ-1:0] xflag;
    } stat_t;

    function automatic ctrl_t ctrl_from_bus(input logic [DATA_W-1:0] d);
        ctrl_t c;
        c.en     = d[EN_LSB  +: NUM_XIRQ];
        c.lvl    = d[LVL_LSB +: NUM_XIRQ];
        c.key_en = d[KEY_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_bus(input ctrl_t c);
        logic [DATA_W-1:0] d;
        d = '0;
        d[EN_LSB  +: NUM_XIRQ] = c.en;
        d[LVL_LSB +: NUM_XIRQ] = c.lvl;
        d[KEY_BIT]             = c.key_en;
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] stat_to_bus(input stat_t s);
        logic [DATA_W-1:0] d;
        d = '0;
        d[EN_LSB +: NUM_XIRQ] = s.xflag;
        d[KEY_BIT]            = s.key_flag;
        return d;
    endfunction

endpackage

// File: rtl/xw_sync.sv
module xw_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= {(STAGES*WIDTH){RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/xw_xirq_chan.sv
module xw_xirq_chan (
    input  logic clk,
    input  logic rst,
    input  logic pin_s,     // synchronised pin level
    input  logic lvl_sel,   // 1: edge or held low
    input  logic clr,       // write-one-to-clear strobe
    output logic flag,
    output logic fall,
    output logic low
);
    logic prev_q;
    logic set_ev;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= pin_s;
    end

    assign fall   = prev_q & ~pin_s;
    assign low    = ~pin_s;
    assign set_ev = fall | (lvl_sel & low);

    // New event has priority over the clear
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= (flag & ~clr) | set_ev;
    end
endmodule

// File: rtl/xw_key_bank.sv
module xw_key_bank #(
    parameter int NUM_KEYS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_KEYS-1:0] pin_s,
    input  logic [NUM_KEYS-1:0] mask,
    input  logic                clr,
    output logic [NUM_KEYS-1:0] latch,
    output logic [NUM_KEYS-1:0] fall,
    output logic                flag
);
    logic [NUM_KEYS-1:0] prev_q;
    logic [NUM_KEYS-1:0] latch_nxt;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= pin_s;
    end

    generate
        for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
            assign fall[k]      = prev_q[k] & ~pin_s[k];
            assign latch_nxt[k] = (latch[k] & ~clr) | fall[k];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            latch <= '0;
            flag  <= 1'b0;
        end else begin
            latch <= latch_nxt;
            flag  <= (flag & ~clr) | (|(latch_nxt & mask));
        end
    end
endmodule

// File: rtl/xirq_wake_ctrl.sv
module xirq_wake_ctrl
    import xw_pkg::*;
#(
    parameter int NUM_KEYS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          xirq_pin,
    input  logic [NUM_KEYS-1:0] key_pin,
    input  logic                wr_en,
    input  logic [1:0]          addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rd_data,
    output logic                xirq_req,
    output logic                key_req
);
    localparam int KEY_W = (NUM_KEYS < DATA_W) ? NUM_KEYS : DATA_W;

    ctrl_t               ctrl_q;
    logic [NUM_KEYS-1:0] kmask_q;
    logic [NUM_XIRQ-1:0] xirq_s;
    logic [NUM_KEYS-1:0] key_s;
    logic [NUM_XIRQ-1:0] xflag;
    logic [NUM_XIRQ-1:0] xfall;
    logic [NUM_XIRQ-1:0] xlow;
    logic [NUM_KEYS-1:0] key_latch;
    logic [NUM_KEYS-1:0] key_fall;
    logic                key_flag;
    logic                wr_stat;
    logic [NUM_XIRQ-1:0] xclr;
    logic                kclr;
    stat_t               stat_v;

    xw_sync #(.WIDTH(NUM_XIRQ), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_x (
        .clk(clk), .rst(rst), .d(xirq_pin), .q(xirq_s)
    );

    xw_sync #(.WIDTH(NUM_KEYS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_k (
        .clk(clk), .rst(rst), .d(key_pin), .q(key_s)
    );

    assign wr_stat = wr_en && (reg_addr_e'(addr) == RA_STAT);
    assign xclr    = {NUM_XIRQ{wr_stat}} & wdata[EN_LSB +: NUM_XIRQ];
    assign kclr    = wr_stat & wdata[KEY_BIT];

    generate
        for (genvar i = 0; i < NUM_XIRQ; i++) begin : g_xirq
            xw_xirq_chan u_chan (
                .clk    (clk),
                .rst    (rst),
                .pin_s  (xirq_s[i]),
                .lvl_sel(ctrl_q.lvl[i]),
                .clr    (xclr[i]),
                .flag   (xflag[i]),
                .fall   (xfall[i]),
                .low    (xlow[i])
            );
        end
    endgenerate

    xw_key_bank #(.NUM_KEYS(NUM_KEYS)) u_keys (
        .clk  (clk),
        .rst  (rst),
        .pin_s(key_s),
        .mask (kmask_q),
        .clr  (kclr),
        .latch(key_latch),
        .fall (key_fall),
        .flag (key_flag)
    );

    // Control and mask registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            kmask_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                RA_CTRL:  ctrl_q  <= ctrl_from_bus(wdata);
                RA_KMASK: kmask_q <= NUM_KEYS'(wdata[KEY_W-1:0]);
                default:  ;
            endcase
        end
    end

    assign stat_v.xflag    = xflag;
    assign stat_v.key_flag = key_flag;

    always_comb begin
        case (reg_addr_e'(addr))
            RA_CTRL:   rd_data = ctrl_to_bus(ctrl_q);
            RA_STAT:   rd_data = stat_to_bus(stat_v);
            RA_KMASK:  rd_data = DATA_W'(kmask_q[KEY_W-1:0]);
            default:   rd_data = DATA_W'(key_latch[KEY_W-1:0]);
        endcase
    end

    assign xirq_req = |(xflag & ctrl_q.en);
    assign key_req  = key_flag & ctrl_q.key_en;

endmodule

// File: rtl/xw_checker.sv
module xw_checker #(
    parameter int NUM_KEYS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [1:0]          addr,
    input logic [7:0]          wdata,
    input logic [1:0]          xflag,
    input logic [1:0]          xen,
    input logic [1:0]          xlvl,
    input logic [1:0]          xlow,
    input logic [NUM_KEYS-1:0] key_latch,
    input logic [NUM_KEYS-1:0] key_fall,
    input logic                key_flag,
    input logic                key_gen,
    input logic                xirq_req,
    input logic                key_req
);
    logic       stat_wr;
    logic [1:0] xclr_w;
    logic       kclr_w;

    assign stat_wr = wr_en && (addr == 2'd1);
    assign xclr_w  = {2{stat_wr}} & wdata[1:0];
    assign kclr_w  = stat_wr & wdata[4];

    generate
        for (genvar i = 0; i < 2; i++) begin : g_x
            // R7: a flag only drops through a write-one clear
            a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
                (xflag[i] && !xclr_w[i]) |=> xflag[i]);
            // R4: level mode holds the flag while the pin is low
            a_r4_level_holds: assert property (@(posedge clk) disable iff (rst)
                (xlvl[i] && xlow[i]) |=> xflag[i]);
        end
        for (genvar k = 0; k < NUM_KEYS; k++) begin : g_k
            // R8: a key latch rises only after a detected falling edge
            a_r8_latch_on_fall: assert property (@(posedge clk) disable iff (rst)
                (key_latch[k] && !$past(key_latch[k])) |-> $past(key_fall[k]));
        end
    endgenerate

    // R6: the shared request needs a pin whose enable is set
    a_r6_req_needs_en: assert property (@(posedge clk) disable iff (rst)
        xirq_req |-> (xen != 2'b00));

    // R10: key request needs the global enable
    a_r10_key_gated: assert property (@(posedge clk) disable iff (rst)
        key_req |-> key_gen);

    // R11: a key clear with no concurrent edge empties every latch
    a_r11_clear_all: assert property (@(posedge clk) disable iff (rst)
        (kclr_w && (key_fall == '0)) |=> (key_latch == '0 && !key_flag));
endmodule

bind xirq_wake_ctrl xw_checker #(.NUM_KEYS(NUM_KEYS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .xflag    (xflag),
    .xen      (ctrl_q.en),
    .xlvl     (ctrl_q.lvl),
    .xlow     (xlow),
    .key_latch(key_latch),
    .key_fall (key_fall),
    .key_flag (key_flag),
    .key_gen  (ctrl_q.key_en),
    .xirq_req (xirq_req),
    .key_req  (key_req)
);

// File: tb/tb_xirq_wake_ctrl.sv
`timescale 1ns/100ps
module tb_xirq_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] xirq_pin = 2'b11;
    logic [7:0] key_pin  = 8'hFF;
    logic       wr_en = 1'b0;
    logic [1:0] addr  = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rd_data;
    logic       xirq_req;
    logic       key_req;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    xirq_wake_ctrl dut (
        .clk(clk), .rst(rst), .xirq_pin(xirq_pin), .key_pin(key_pin),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
        .xirq_req(xirq_req), .key_req(key_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
        addr = a;
        #0.5;
        check(req, rd_data, exp);
    endtask

    task automatic t_reset;
        rd("R1 ctrl", 2'd0, 8'h00);
        rd("R1 stat", 2'd1, 8'h00);
        rd("R1 mask", 2'd2, 8'h00);
        rd("R1 latch", 2'd3, 8'h00);
        check("R1 xirq_req", {7'd0, xirq_req}, 8'h00);
        check("R1 key_req", {7'd0, key_req}, 8'h00);
    endtask

    task automatic t_edge;
        xirq_pin[0] = 1'b0;
        tick(2);
        rd("R2 not before third edge", 2'd1, 8'h00);
        tick(1);
        rd("R2 flag on third edge", 2'd1, 8'h01);
        check("R5 disabled no req", {7'd0, xirq_req}, 8'h00);
        wr(2'd1, 8'h01);
        tick(4);
        rd("R3 held low no reflag", 2'd1, 8'h00);
        xirq_pin[0] = 1'b1;
        tick(4);
        rd("R2 rising sets nothing", 2'd1, 8'h00);
    endtask

    task automatic t_enable;
        xirq_pin[1] = 1'b0;
        tick(4);
        xirq_pin[1] = 1'b1;
        rd("R5 flag while disabled", 2'd1, 8'h02);
        wr(2'd0, 8'h02);
        check("R5 enable raises req", {7'd0, xirq_req}, 8'h01);
        wr(2'd1, 8'h00);
        rd("R7 zero write keeps", 2'd1, 8'h02);
        wr(2'd1, 8'h02);
        check("R7 clear drops req", {7'd0, xirq_req}, 8'h00);
        wr(2'd0, 8'h00);
        xirq_pin[0] = 1'b0;
        tick(4);
        xirq_pin[0] = 1'b1;
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h01);
        check("R5 clear before enable", {7'd0, xirq_req}, 8'h00);
        tick(4);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_shared;
        wr(2'd0, 8'h03);
        xirq_pin[1] = 1'b0;
        tick(4);
        xirq_pin[1] = 1'b1;
        rd("R6 only pin1 flag", 2'd1, 8'h02);
        check("R6 pin1 alone drives req", {7'd0, xirq_req}, 8'h01);
        wr(2'd1, 8'h03);
        check("R6 req low after clear", {7'd0, xirq_req}, 8'h00);
        tick(4);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_level;
        wr(2'd0, 8'h05);
        xirq_pin[0] = 1'b0;
        tick(4);
        check("R4 level req", {7'd0, xirq_req}, 8'h01);
        wr(2'd1, 8'h01);
        rd("R4 clear while low", 2'd1, 8'h01);
        xirq_pin[0] = 1'b1;
        tick(4);
        wr(2'd1, 8'h01);
        tick(2);
        rd("R4 released then cleared", 2'd1, 8'h00);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_race;
        xirq_pin[0] = 1'b0;
        tick(4);
        xirq_pin[0] = 1'b1;
        tick(4);
        xirq_pin[0] = 1'b0;
        tick(2);
        wr(2'd1, 8'h01);
        rd("R7 event beats clear", 2'd1, 8'h01);
        xirq_pin[0] = 1'b1;
        tick(4);
        wr(2'd1, 8'h01);
        rd("R7 plain clear", 2'd1, 8'h00);
    endtask

    task automatic t_keys;
        wr(2'd2, 8'h0F);
        wr(2'd0, 8'h10);
        key_pin[5] = 1'b0;
        tick(4);
        rd("R8 unmasked latch", 2'd3, 8'h20);
        rd("R9 unmasked no flag", 2'd1, 8'h00);
        check("R10 no req", {7'd0, key_req}, 8'h00);
        key_pin[2] = 1'b0;
        tick(4);
        rd("R9 masked sets flag", 2'd1, 8'h10);
        check("R10 req", {7'd0, key_req}, 8'h01);
        key_pin[2] = 1'b1;
        key_pin[5] = 1'b1;
        tick(4);
        rd("R8 rising no change", 2'd3, 8'h24);
        wr(2'd1, 8'h10);
        rd("R11 latches cleared", 2'd3, 8'h00);
        rd("R11 flag cleared", 2'd1, 8'h00);
        check("R10 req gone", {7'd0, key_req}, 8'h00);
        wr(2'd0, 8'h00);
        key_pin[0] = 1'b0;
        tick(4);
        rd("R10 flag with global off", 2'd1, 8'h10);
        check("R10 gated by global", {7'd0, key_req}, 8'h00);
        key_pin[0] = 1'b1;
        tick(4);
        wr(2'd1, 8'h10);
    endtask

    task automatic t_key_race;
        key_pin[3] = 1'b0;
        tick(4);
        key_pin[1] = 1'b0;
        tick(2);
        wr(2'd1, 8'h10);
        rd("R11 edge survives clear", 2'd3, 8'h02);
        rd("R11 flag from surviving edge", 2'd1, 8'h10);
        key_pin[1] = 1'b1;
        key_pin[3] = 1'b1;
        tick(4);
        wr(2'd1, 8'h10);
        rd("R11 final clear", 2'd3, 8'h00);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_edge();
        t_enable();
        t_shared();
        t_level();
        t_race();
        t_keys();
        t_key_race();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule